// File: doc/BRIEF.md
# Linked Descriptor Table Walker

The walker moves a stream of 31-bit capture words into host memory pages of 4096 bytes. The host builds a circular chain of descriptor tables in memory. Each table page starts with the frame number of the next table, and the frame numbers of its data pages follow in order. The walker reads a table's next-pointer word first. It then fetches one data-page frame at a time and fills that page with captured words from word 0 upwards, so the final word of every page is always the last one written. After the last entry of a table it moves on to the table that the pointer names. A page address is its frame number shifted left by 12.

The host limits how far the walker may run ahead with a table credit counter, using a clear command and an increment command. The walker takes one credit before it reads each table. With no credit it waits, and incoming words collect in a small FIFO. When a word arrives while the FIFO is full, that word is lost, and the next word the FIFO accepts is tagged in bit 31 so that the host can see the gap. The host loads the first table frame together with a start pulse and halts the walk with a stop pulse. Memory access goes through a simple request/ready port, with read data returned on a separate valid strobe.

The capture input is valid/ready, but the source is not required to wait. While `in_ready_o` is low, a word offered with `in_valid_i` is discarded and counted as a gap. The memory port holds each request, with its address and data unchanged, until `mem_ready_i` is high at a clock edge.

Top module: `desc_chain_walker`

## Requirements
- R1: After reset the walker is idle: `mem_req_o` is 0 and `in_ready_o` is 1.
- R2: After a start pulse, and once a credit is available, the walker reads the table's word 0 at byte address `first_frame<<12`. It then reads the entry words 1 to TABLE_ENTRIES, at table base plus 4·i in ascending order, one entry before each data page.
- R3: Each data page receives PAGE_WORDS writes at page base plus 4·k with k ascending, so the final word is written last. The written data are the accepted capture words in arrival order, with the payload in bits 30:0.
- R4: After the last entry of a table, the next table read starts at the frame number taken from word 0 of the current table, so a circular chain wraps back to its first table.
- R5: Each table uses one credit before its word-0 read. With zero credit the walker issues no memory request. An increment adds one credit, saturating at the counter maximum. A clear sets the count to zero and takes priority over an increment in the same cycle.
- R6: While the walker is running, the FIFO buffers up to FIFO_DEPTH words, and `in_ready_o` is 0 exactly when the FIFO is full.
- R7: A word offered while `in_ready_o` is 0 is dropped. The first word accepted after one or more drops is written with bit 31 = 1. Every other word is written with bit 31 = 0.
- R8: A stop pulse returns the walker to idle at the next edge. No memory request follows it, the FIFO is emptied and the gap tag is cleared. A start pulse is honoured only while idle.
- R9: While idle, offered words are accepted (`in_ready_o` = 1) and discarded, and never written.
- R10: A memory request is held with a stable address and direction until accepted. Each read waits for `mem_rvalid_i` before the walker goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| first_frame_i | input | FRAME_W | Frame number of the first table, sampled with start |
| start_i | input | 1 | Start pulse, honoured while idle |
| stop_i | input | 1 | Stop pulse, returns the walker to idle |
| credit_clear_i | input | 1 | Sets the table credit to zero |
| credit_inc_i | input | 1 | Adds one table credit |
| in_valid_i | input | 1 | Capture word present |
| in_ready_o | output | 1 | Capture word will be taken (low only when running with a full FIFO) |
| in_data_i | input | 31 | Capture word payload |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | FRAME_W+12 | Byte address |
| mem_wdata_o | output | 32 | Write data: tag in bit 31, payload below |
| mem_ready_i | input | 1 | Request accepted at this edge |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | FRAME_W | Low frame-number bits of the read word |

## Verification
A slow, steady stream with a memory that stalls every third cycle walks two chained tables. This separates correct address order, entry sequencing and write data from handshake mistakes. A burst offered while credit is exhausted fills the FIFO and forces drops. That run shows whether back-pressure starts at the right depth, whether the gap tag lands only on the first word after the loss, and whether the chain wraps back to its first table. A stop followed by idle traffic, then a clear that overrides earlier increments before a fresh start on the second table, shows that halting, discarding and credit accounting are independent of the history before them.

// File: rtl/dtw_pkg.sv
package dtw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CREDIT,
    ST_PTR_REQ,
    ST_PTR_WAIT,
    ST_ENT_REQ,
    ST_ENT_WAIT,
    ST_FILL
  } walk_state_e;
endpackage

// File: rtl/dtw_fifo.sv
// Capture buffer: holds words while the walker waits for credit or memory.
module dtw_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16   // power of two
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0] store [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;

  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
  assign dout  = store[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        store[wr_ptr] <= din;
        wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
      end
      if (pop)
        rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_FIFO_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !flush) |-> !full); // R6
  AST_FIFO_NO_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !flush) |-> !empty); // R3
endmodule

// File: rtl/dtw_credit.sv
// Table credit counter: host adds credits, walker takes one per table.
module dtw_credit #(
  parameter int CW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  input  logic take,
  output logic has_credit
);
  localparam logic [CW-1:0] CMAX = '1;

  logic [CW-1:0] cnt;

  assign has_credit = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt <= '0;
    end else begin
      case ({inc, take})
        2'b10:   cnt <= (cnt == CMAX) ? cnt : cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_CREDIT_TAKE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> has_credit); // R5
endmodule

// File: rtl/desc_chain_walker.sv
module desc_chain_walker
  import dtw_pkg::*;
#(
  parameter int FRAME_W       = 20,
  parameter int PAGE_WORDS    = 1024,
  parameter int TABLE_ENTRIES = 511,
  parameter int FIFO_DEPTH    = 16,
  parameter int CREDIT_W      = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [FRAME_W-1:0]      first_frame_i,
  input  logic                    start_i,
  input  logic                    stop_i,
  input  logic                    credit_clear_i,
  input  logic                    credit_inc_i,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [30:0]             in_data_i,
  output logic                    mem_req_o,
  output logic                    mem_we_o,
  output logic [FRAME_W+11:0]     mem_addr_o,
  output logic [31:0]             mem_wdata_o,
  input  logic                    mem_ready_i,
  input  logic                    mem_rvalid_i,
  input  logic [FRAME_W-1:0]      mem_rdata_i
);
  localparam int OFF_W = 12;
  localparam int ENT_W = $clog2(TABLE_ENTRIES + 1);
  localparam int WRD_W = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;

  walk_state_e        state;
  logic [FRAME_W-1:0] table_frame, next_frame, data_frame;
  logic [ENT_W-1:0]   ent_idx;
  logic [WRD_W-1:0]   word_idx;
  logic               gap_q;

  logic        running, fifo_full, fifo_empty, push, drop, pop, accept;
  logic        has_credit, take;
  logic [31:0] fifo_dout;

  assign running    = (state != ST_IDLE);
  assign in_ready_o = !running || !fifo_full;
  assign push       = running && in_valid_i && !fifo_full && !stop_i;
  assign drop       = running && in_valid_i && fifo_full;
  assign take       = (state == ST_CREDIT) && has_credit && !stop_i;
  assign accept     = mem_req_o && mem_ready_i;
  assign pop        = (state == ST_FILL) && accept && !stop_i;

  dtw_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (stop_i || !running),
    .push  (push),
    .din   ({gap_q, in_data_i}),
    .pop   (pop),
    .dout  (fifo_dout),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  dtw_credit #(.CW(CREDIT_W)) u_credit (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (credit_clear_i),
    .inc        (credit_inc_i),
    .take       (take),
    .has_credit (has_credit)
  );

  // Memory request generation
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = fifo_dout;
    case (state)
      ST_PTR_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {table_frame, OFF_W'(0)};
      end
      ST_ENT_REQ: begin
        mem_req_o  = 1'b1;
        mem_addr_o = {table_frame, OFF_W'(ent_idx) << 2};
      end
      ST_FILL: begin
        mem_req_o  = !fifo_empty;
        mem_we_o   = 1'b1;
        mem_addr_o = {data_frame, OFF_W'(word_idx) << 2};
      end
      default: ;
    endcase
  end

  // Gap tag: set by a dropped word, cleared by the next accepted word
  always_ff @(posedge clk) begin
    if (!rst_n || !running || stop_i) gap_q <= 1'b0;
    else if (drop)                    gap_q <= 1'b1;
    else if (push)                    gap_q <= 1'b0;
  end

  // Walk sequencer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      table_frame <= '0;
      next_frame  <= '0;
      data_frame  <= '0;
      ent_idx     <= '0;
      word_idx    <= '0;
    end else if (stop_i) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          table_frame <= first_frame_i;
          state       <= ST_CREDIT;
        end
        ST_CREDIT: if (has_credit) state <= ST_PTR_REQ;
        ST_PTR_REQ: if (accept) state <= ST_PTR_WAIT;
        ST_PTR_WAIT: if (mem_rvalid_i) begin
          next_frame <= mem_rdata_i;
          ent_idx    <= ENT_W'(1);
          state      <= ST_ENT_REQ;
        end
        ST_ENT_REQ: if (accept) state <= ST_ENT_WAIT;
        ST_ENT_WAIT: if (mem_rvalid_i) begin
          data_frame <= mem_rdata_i;
          word_idx   <= '0;
          state      <= ST_FILL;
        end
        ST_FILL: if (accept) begin
          if (word_idx == WRD_W'(PAGE_WORDS - 1)) begin
            if (ent_idx == ENT_W'(TABLE_ENTRIES)) begin
              table_frame <= next_frame;
              state       <= ST_CREDIT;
            end else begin
              ent_idx <= ent_idx + 1'b1;
              state   <= ST_ENT_REQ;
            end
          end else begin
            word_idx <= word_idx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i && !stop_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))); // R10
  AST_STOP_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!mem_req_o && in_ready_o)); // R8
  AST_NO_READ_WITHOUT_CREDIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_CREDIT && !$past(has_credit) && !$past(stop_i)) |-> !mem_req_o); // R5
endmodule

// File: tb/sim_desc_chain_walker.sv
module sim_desc_chain_walker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [19:0] first_frame = '0;
  logic start = 0, stop = 0, cclr = 0, cinc = 0;
  logic in_valid = 0;
  logic [30:0] in_data = '0;
  logic in_ready, mem_req, mem_we, mem_ready, mem_rvalid;
  logic [31:0] mem_addr, mem_wdata;
  logic [19:0] mem_rdata;

  desc_chain_walker #(.FRAME_W(20), .PAGE_WORDS(4), .TABLE_ENTRIES(3),
                      .FIFO_DEPTH(4), .CREDIT_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .first_frame_i(first_frame), .start_i(start),
    .stop_i(stop), .credit_clear_i(cclr), .credit_inc_i(cinc),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ready_i(mem_ready),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata));

  // Memory model: frames 0..31, words 0..3, one-cycle read latency
  logic [31:0] mem [0:31][0:3];
  logic [31:0] rd_log [0:63];
  logic [31:0] wa_log [0:63];
  logic [31:0] wd_log [0:63];
  int rd_n, wr_n, bad_acc, cyc;
  logic stall_mode = 1'b0;
  logic [19:0] a_frame;
  logic [9:0]  a_word;
  assign a_frame = mem_addr[31:12];
  assign a_word  = mem_addr[11:2];

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_n <= 0; wr_n <= 0; bad_acc <= 0; cyc <= 0;
      mem_rvalid <= 0; mem_rdata <= '0; mem_ready <= 1'b1;
      mem[1][0] <= 32'd2;  mem[1][1] <= 32'd10; mem[1][2] <= 32'd11; mem[1][3] <= 32'd12;
      mem[2][0] <= 32'd1;  mem[2][1] <= 32'd13; mem[2][2] <= 32'd14; mem[2][3] <= 32'd15;
    end else begin
      cyc <= cyc + 1;
      mem_ready <= stall_mode ? ((cyc % 3) != 1) : 1'b1;
      mem_rvalid <= 1'b0;
      if (mem_req && mem_ready) begin
        if (a_frame >= 20'd32 || a_word >= 10'd4 || mem_addr[1:0] != 2'b00) begin
          bad_acc <= bad_acc + 1;
        end else if (mem_we) begin
          mem[a_frame[4:0]][a_word[1:0]] <= mem_wdata;
          if (wr_n < 64) begin wa_log[wr_n] <= mem_addr; wd_log[wr_n] <= mem_wdata; end
          wr_n <= wr_n + 1;
        end else begin
          mem_rdata  <= mem[a_frame[4:0]][a_word[1:0]][19:0];
          mem_rvalid <= 1'b1;
          if (rd_n < 64) rd_log[rd_n] <= mem_addr;
          rd_n <= rd_n + 1;
        end
      end
    end
  end

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_inc();
    @(negedge clk) cinc = 1; @(negedge clk) cinc = 0;
  endtask

  // Offer one word; returns whether in_ready was high while it was offered
  task automatic send(input int p, output logic got);
    @(negedge clk);
    in_valid = 1; in_data = 31'(p);
    #1 got = in_ready;
    @(negedge clk);
    in_valid = 0;
  endtask

  function automatic logic [31:0] baddr(input int fr, input int w);
    return (32'(fr) << 12) + 32'(4 * w);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin : main
    logic g;
    int base_r, base_w;
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(1);
    // R1 reset state
    chk("R1", "mem_req after reset", {31'd0, mem_req}, 32'd0);
    chk("R1", "in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R9 idle words are taken and discarded
    for (int i = 0; i < 3; i++) begin
      send(100 + i, g);
      chk("R9", "in_ready while idle", {31'd0, g}, 32'd1);
    end
    wait_cyc(5);
    chk("R9", "no writes while idle", 32'(wr_n), 32'd0);

    // Two chained tables, stalling memory, slow stream
    stall_mode = 1;
    pulse_inc(); pulse_inc();
    @(negedge clk) begin first_frame = 20'd1; start = 1; end
    @(negedge clk) start = 0;
    begin
      int notready = 0;
      for (int k = 0; k < 24; k++) begin
        send(k, g);
        if (!g) notready++;
        wait_cyc(2);
      end
      chk("R6", "no back-pressure on slow stream", 32'(notready), 32'd0);
    end
    wait_cyc(30);
    chk("R2", "read count after two tables", 32'(rd_n), 32'd8);
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 4; i++)
        chk(t == 0 ? "R2" : "R4", "table read address", rd_log[t*4+i], baddr(t + 1, i));
    chk("R3", "write count two tables", 32'(wr_n), 32'd24);
    for (int k = 0; k < 24; k++) begin
      chk("R3", "write address", wa_log[k], baddr(10 + k / 4, k % 4));
      chk("R7", "write data untagged", wd_log[k], 32'(k));
    end

    // R5 no credit: walker holds off
    wait_cyc(20);
    chk("R5", "no read without credit", 32'(rd_n), 32'd8);
    for (int k = 24; k < 28; k++) begin
      send(k, g);
      chk("R6", "buffered while stalled", {31'd0, g}, 32'd1);
    end
    for (int k = 28; k < 30; k++) begin
      send(k, g);
      chk("R6", "in_ready low when full", {31'd0, g}, 32'd0);
    end
    chk("R5", "still no read or write", 32'(rd_n + wr_n), 32'd32);

    // Credit: wrap to first table, drain FIFO
    pulse_inc();
    wait_cyc(30);
    chk("R4", "wrap read count", 32'(rd_n), 32'd11);
    chk("R4", "wrap pointer read", rd_log[8], baddr(1, 0));
    chk("R4", "wrap entry1 read", rd_log[9], baddr(1, 1));
    chk("R2", "wrap entry2 read", rd_log[10], baddr(1, 2));
    for (int k = 24; k < 28; k++) begin
      chk("R3", "drained write address", wa_log[k], baddr(10, k - 24));
      chk("R7", "drained data untagged", wd_log[k], 32'(k));
    end
    send(30, g);
    send(31, g);
    wait_cyc(10);
    chk("R7", "gap-tagged word", wd_log[28], 32'h8000_0000 | 32'd30);
    chk("R7", "gap-tagged address", wa_log[28], baddr(11, 0));
    chk("R7", "following word untagged", wd_log[29], 32'd31);

    // R8 stop
    @(negedge clk) stop = 1;
    @(negedge clk) stop = 0;
    for (int i = 0; i < 4; i++) begin
      chk("R8", "no request after stop", {31'd0, mem_req}, 32'd0);
      wait_cyc(1);
    end
    send(40, g);
    chk("R9", "idle after stop takes word", {31'd0, g}, 32'd1);
    wait_cyc(5);
    chk("R9", "idle word not written", 32'(wr_n), 32'd30);

    // R5 clear overrides earlier increments; restart on second table
    pulse_inc(); pulse_inc(); pulse_inc();
    @(negedge clk) cclr = 1;
    @(negedge clk) cclr = 0;
    @(negedge clk) begin first_frame = 20'd2; start = 1; end
    @(negedge clk) start = 0;
    base_r = rd_n;
    wait_cyc(20);
    chk("R5", "cleared credit blocks reads", 32'(rd_n), 32'(base_r));
    pulse_inc();
    wait_cyc(15);
    chk("R5", "read after fresh credit", 32'(rd_n), 32'(base_r + 2));
    chk("R8", "restart pointer read", rd_log[base_r], baddr(2, 0));
    chk("R2", "restart entry read", rd_log[base_r + 1], baddr(2, 1));
    base_w = wr_n;
    for (int k = 50; k < 54; k++) send(k, g);
    wait_cyc(15);
    for (int k = 0; k < 4; k++) begin
      chk("R3", "restart write address", wa_log[base_w + k], baddr(13, k));
      chk("R8", "restart data untagged", wd_log[base_w + k], 32'(50 + k));
    end
    chk("R10", "accesses inside model range", 32'(bad_acc), 32'd0);
    report();
  end
endmodule